// File: doc/BRIEF.md
# Multithreaded Direct-Mapped Branch Target Buffer

This block predicts the destination of taken branches for a fetch unit that interleaves several hardware threads. A fetch PC and the thread number of the requester are applied to the lookup port. In the same cycle, with no clock edge in the path, the block reports a hit flag and the predicted target. The PC selects one slot. The slot hits only if it is valid, if its stored partial tag matches the tag bits of the PC, and if it was written by the same thread. On a miss the target reads as all zeros. The separate hit flag lets a real zero target be told apart from a miss.

When a taken branch resolves, the update port writes the branch PC, the thread number and the resolved target. On the next rising clock edge that overwrites whatever the indexed slot held, including an entry that another thread owns. The active-low reset clears every valid bit. A synchronous flush does the same thing in one cycle and leaves the target storage as it is. Each cycle the write side decodes its inputs into one of three named operations: OP_IDLE (nothing happens), OP_WRITE (one slot is written) and OP_CLEAR (all valid bits are cleared). The decoder moves freely between them from cycle to cycle, and a flush always selects OP_CLEAR, even when an update is also present. The entry count, the tag width and the instruction alignment shift are parameters. A non-power-of-two entry count stops elaboration.

Top module: `btb_mt_direct`

## Requirements
- R1: After reset, every lookup misses: lk_hit is 0 and lk_target is 0.
- R2: The slot index is pc[ALIGN_SHIFT +: log2(ENTRIES)], and the tag is the TAG_W bits directly above the index. PC bits below the index and above the tag are ignored, so two PCs that differ only in those bits share an entry and both hit.
- R3: A lookup hits only when three conditions hold together: the slot is valid, the stored tag equals the tag of the PC, and the stored thread number equals lk_tid.
- R4: Whenever lk_hit is 0, lk_target is all zeros.
- R5: An update with up_en=1 (and flush=0) overwrites the indexed slot with the valid bit, the tag, the thread number and the target. The previous occupant is evicted, whichever thread owned it.
- R6: An update takes effect at the rising edge that samples it. A lookup of the same slot in the cycle that presents the update still sees the old contents.
- R7: A flush held for one cycle leaves every slot invalid, so all later lookups miss until a slot is written again.
- R8: When flush and up_en are both 1 in the same cycle, the flush wins and the written slot does not become valid.
- R9: A hit on an entry whose target is zero gives lk_hit=1 with lk_target=0.
- R10: Lookup is combinational: lk_hit and lk_target follow a change of lk_pc or lk_tid within the same clock phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; invalidates all slots |
| flush | input | 1 | Synchronous invalidate of all slots |
| lk_pc | input | ADDR_W | Fetch PC to look up |
| lk_tid | input | TID_W | Thread number of the lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_target | output | TGT_W | Predicted target, zero on a miss |
| up_en | input | 1 | Write a resolved taken branch |
| up_pc | input | ADDR_W | PC of the resolved branch |
| up_tid | input | TID_W | Thread number of the resolved branch |
| up_target | input | TGT_W | Resolved branch target |

## Verification
The assertions assume the following about the inputs:
- flush, up_en and the update fields are synchronous to clk and carry known values at every rising edge once reset has been released.
- up_en is low while rst_n is asserted, so the first sampled write follows the reset release.

The bench changes every input only just after a falling edge and holds up_en and flush low during reset, which keeps the stimulus within these assumptions. Lookups are sampled one nanosecond into the low phase, before the next write edge. This places the same-cycle and flush-priority cases exactly on the edge where the write decision is taken.

// File: rtl/btb_mt_pkg.sv
`timescale 1ns/1ps
package btb_mt_pkg;

    // Operation chosen by the write side of the storage each cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CLEAR = 2'd2
    } btb_op_e;

    function automatic bit is_pow2(input int unsigned n);
        return (n >= 2) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/btb_pc_split.sv
`timescale 1ns/1ps
module btb_pc_split #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ALIGN_SHIFT = 2,
    parameter int unsigned IDX_W       = 6,
    parameter int unsigned TAG_W       = 8
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    localparam int unsigned TAG_LO = ALIGN_SHIFT + IDX_W;

    if (TAG_LO + TAG_W > ADDR_W) begin : g_bad_fields
        $error("index and tag fields do not fit in the PC width");
    end

    // Alignment bits and bits above the tag take no part in the lookup
    logic unused_pc_bits;
    assign unused_pc_bits = ^pc;

    assign idx = pc[ALIGN_SHIFT +: IDX_W];
    assign tag = pc[TAG_LO +: TAG_W];
endmodule

// File: rtl/btb_store.sv
`timescale 1ns/1ps
module btb_store
    import btb_mt_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned TAG_W   = 8,
    parameter int unsigned TID_W   = 2,
    parameter int unsigned TGT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TID_W-1:0] wr_tid,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TID_W-1:0] rd_tid,
    output logic [TGT_W-1:0] rd_tgt
);
    btb_op_e op;

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [TID_W-1:0]   tid_q [ENTRIES];
    logic [TGT_W-1:0]   tgt_q [ENTRIES];

    // Decode of the write-side operation; flush outranks the update
    always_comb begin
        unique case ({flush, wr_en})
            2'b00:        op = OP_IDLE;
            2'b01:        op = OP_WRITE;
            2'b10, 2'b11: op = OP_CLEAR;
            default:      op = OP_IDLE;
        endcase
    end

    // Valid bits: the only state touched by reset and flush
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: vld_q <= '0;
                OP_WRITE: vld_q[wr_idx] <= 1'b1;
                default:  vld_q <= vld_q;
            endcase
        end
    end

    // Payload storage: written only on OP_WRITE, never cleared
    always_ff @(posedge clk) begin
        if (op == OP_WRITE) begin
            tag_q[wr_idx] <= wr_tag;
            tid_q[wr_idx] <= wr_tid;
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    assign rd_vld = vld_q[rd_idx];
    assign rd_tag = tag_q[rd_idx];
    assign rd_tid = tid_q[rd_idx];
    assign rd_tgt = tgt_q[rd_idx];

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));

    // R8
    flush_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && wr_en) |=> !vld_q[$past(wr_idx)]);

    // R5
    write_fills_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (vld_q[$past(wr_idx)]
                               && tid_q[$past(wr_idx)] == $past(wr_tid)
                               && tag_q[$past(wr_idx)] == $past(wr_tag)
                               && tgt_q[$past(wr_idx)] == $past(wr_tgt)));
endmodule

// File: rtl/btb_match.sv
`timescale 1ns/1ps
module btb_match #(
    parameter int unsigned TAG_W = 8,
    parameter int unsigned TID_W = 2,
    parameter int unsigned TGT_W = 32
) (
    input  logic             slot_vld,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [TID_W-1:0] slot_tid,
    input  logic [TGT_W-1:0] slot_tgt,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TID_W-1:0] req_tid,
    output logic             hit,
    output logic [TGT_W-1:0] target
);
    logic tag_eq;
    logic tid_eq;

    always_comb begin
        tag_eq = (slot_tag == req_tag);
        tid_eq = (slot_tid == req_tid);
        hit    = slot_vld && tag_eq && tid_eq;
        target = hit ? slot_tgt : '0;
    end
endmodule

// File: rtl/btb_mt_direct.sv
`timescale 1ns/1ps
module btb_mt_direct
    import btb_mt_pkg::*;
#(
    parameter int unsigned ENTRIES     = 64,
    parameter int unsigned TAG_W       = 8,
    parameter int unsigned ALIGN_SHIFT = 2,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned TID_W       = 2,
    parameter int unsigned TGT_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [TID_W-1:0]  lk_tid,
    output logic              lk_hit,
    output logic [TGT_W-1:0]  lk_target,
    input  logic              up_en,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic [TID_W-1:0]  up_tid,
    input  logic [TGT_W-1:0]  up_target
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    if (!is_pow2(ENTRIES)) begin : g_bad_entries
        $error("ENTRIES must be a power of two, at least 2");
    end

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             slot_vld;
    logic [TAG_W-1:0] slot_tag;
    logic [TID_W-1:0] slot_tid;
    logic [TGT_W-1:0] slot_tgt;

    btb_pc_split #(.ADDR_W(ADDR_W), .ALIGN_SHIFT(ALIGN_SHIFT),
                   .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_lk (
        .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
    );

    btb_pc_split #(.ADDR_W(ADDR_W), .ALIGN_SHIFT(ALIGN_SHIFT),
                   .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_up (
        .pc(up_pc), .idx(up_idx), .tag(up_tag)
    );

    btb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
                .TID_W(TID_W), .TGT_W(TGT_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .wr_en  (up_en),
        .wr_idx (up_idx),
        .wr_tag (up_tag),
        .wr_tid (up_tid),
        .wr_tgt (up_target),
        .rd_idx (lk_idx),
        .rd_vld (slot_vld),
        .rd_tag (slot_tag),
        .rd_tid (slot_tid),
        .rd_tgt (slot_tgt)
    );

    btb_match #(.TAG_W(TAG_W), .TID_W(TID_W), .TGT_W(TGT_W)) u_match (
        .slot_vld (slot_vld),
        .slot_tag (slot_tag),
        .slot_tid (slot_tid),
        .slot_tgt (slot_tgt),
        .req_tag  (lk_tag),
        .req_tid  (lk_tid),
        .hit      (lk_hit),
        .target   (lk_target)
    );

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_target == '0));

    // R1
    reset_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n)) |-> !lk_hit);
endmodule

// File: tb/sim_btb_mt_direct.sv
`timescale 1ns/1ps
module sim_btb_mt_direct;
    localparam int unsigned ENTRIES = 64;
    localparam int unsigned TAG_W   = 8;
    localparam int unsigned SHIFT   = 2;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned TID_W   = 2;
    localparam int unsigned TGT_W   = 32;
    localparam int unsigned IDX_W   = $clog2(ENTRIES);
    localparam int unsigned TAG_LO  = SHIFT + IDX_W;
    localparam int unsigned HI_LO   = TAG_LO + TAG_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic [ADDR_W-1:0] lk_pc = '0;
    logic [TID_W-1:0]  lk_tid = '0;
    logic              lk_hit;
    logic [TGT_W-1:0]  lk_target;
    logic              up_en = 1'b0;
    logic [ADDR_W-1:0] up_pc = '0;
    logic [TID_W-1:0]  up_tid = '0;
    logic [TGT_W-1:0]  up_target = '0;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    btb_mt_direct #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ALIGN_SHIFT(SHIFT),
                    .ADDR_W(ADDR_W), .TID_W(TID_W), .TGT_W(TGT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_pc(lk_pc), .lk_tid(lk_tid), .lk_hit(lk_hit), .lk_target(lk_target),
        .up_en(up_en), .up_pc(up_pc), .up_tid(up_tid), .up_target(up_target)
    );

    function automatic logic [ADDR_W-1:0] mk_pc(input int unsigned tag,
                                                input int unsigned idx,
                                                input int unsigned hi,
                                                input int unsigned lo);
        logic [ADDR_W-1:0] p;
        p = (ADDR_W'(hi) << HI_LO) | (ADDR_W'(tag) << TAG_LO)
          | (ADDR_W'(idx) << SHIFT) | ADDR_W'(lo);
        return p;
    endfunction

    task automatic check(input string req, input logic exp_hit,
                         input logic [TGT_W-1:0] exp_tgt);
        n_checks++;
        if (lk_hit !== exp_hit || lk_target !== exp_tgt) begin
            n_fails++;
            $display("FAIL %s: hit=%0b target=%h expected hit=%0b target=%h",
                     req, lk_hit, lk_target, exp_hit, exp_tgt);
        end
    endtask

    task automatic write(input logic [ADDR_W-1:0] pc, input logic [TID_W-1:0] tid,
                         input logic [TGT_W-1:0] tgt);
        @(negedge clk);
        up_en = 1'b1; up_pc = pc; up_tid = tid; up_target = tgt;
        @(negedge clk);
        up_en = 1'b0;
    endtask

    task automatic look(input string req, input logic [ADDR_W-1:0] pc,
                        input logic [TID_W-1:0] tid, input logic exp_hit,
                        input logic [TGT_W-1:0] exp_tgt);
        @(negedge clk);
        lk_pc = pc; lk_tid = tid;
        #1;
        check(req, exp_hit, exp_tgt);
    endtask

    task automatic t_reset();
        look("R1 after reset", mk_pc(5, 3, 0, 0), 2'd0, 1'b0, '0);
        look("R1 after reset other slot", mk_pc(0, 63, 0, 0), 2'd1, 1'b0, '0);
    endtask

    task automatic t_basic_and_comb();
        write(mk_pc(5, 3, 0, 0), 2'd1, 32'hDEAD_0000);
        look("R3 basic hit", mk_pc(5, 3, 0, 0), 2'd1, 1'b1, 32'hDEAD_0000);
        // R10: change lookup inputs within one low phase, no edge between
        @(negedge clk);
        lk_pc = mk_pc(5, 3, 0, 0); lk_tid = 2'd1;
        #0.5; check("R10 comb hit", 1'b1, 32'hDEAD_0000);
        lk_pc = mk_pc(5, 4, 0, 0);
        #0.5; check("R10 comb miss", 1'b0, '0);
        lk_pc = mk_pc(5, 3, 0, 0);
        #0.5; check("R10 comb hit again", 1'b1, 32'hDEAD_0000);
    endtask

    task automatic t_alias();
        look("R2 alias above tag", mk_pc(5, 3, 16'hABCD, 0), 2'd1, 1'b1, 32'hDEAD_0000);
        look("R2 alignment bits ignored", mk_pc(5, 3, 0, 3), 2'd1, 1'b1, 32'hDEAD_0000);
        look("R4 tag mismatch miss", mk_pc(6, 3, 0, 0), 2'd1, 1'b0, '0);
    endtask

    task automatic t_tid();
        look("R3 thread mismatch", mk_pc(5, 3, 0, 0), 2'd2, 1'b0, '0);
    endtask

    task automatic t_evict();
        write(mk_pc(9, 3, 0, 0), 2'd2, 32'h1357_9BDF);
        look("R5 old owner evicted", mk_pc(5, 3, 0, 0), 2'd1, 1'b0, '0);
        look("R5 new owner hits", mk_pc(9, 3, 0, 0), 2'd2, 1'b1, 32'h1357_9BDF);
    endtask

    task automatic t_zero_target();
        write(mk_pc(1, 10, 0, 0), 2'd0, 32'h0);
        look("R9 zero target hit", mk_pc(1, 10, 0, 0), 2'd0, 1'b1, 32'h0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        up_en = 1'b1; up_pc = mk_pc(2, 20, 0, 0); up_tid = 2'd3; up_target = 32'h55;
        lk_pc = mk_pc(2, 20, 0, 0); lk_tid = 2'd3;
        #1; check("R6 same cycle sees old", 1'b0, '0);
        @(negedge clk);
        up_en = 1'b0;
        #1; check("R6 visible after edge", 1'b1, 32'h55);
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        look("R7 flushed slot A", mk_pc(9, 3, 0, 0), 2'd2, 1'b0, '0);
        look("R7 flushed slot B", mk_pc(2, 20, 0, 0), 2'd3, 1'b0, '0);
        look("R7 flushed slot C", mk_pc(1, 10, 0, 0), 2'd0, 1'b0, '0);
        write(mk_pc(7, 40, 0, 0), 2'd1, 32'hCAFE_F00D);
        look("R5 write after flush", mk_pc(7, 40, 0, 0), 2'd1, 1'b1, 32'hCAFE_F00D);
    endtask

    task automatic t_flush_priority();
        @(negedge clk);
        flush = 1'b1;
        up_en = 1'b1; up_pc = mk_pc(4, 30, 0, 0); up_tid = 2'd0; up_target = 32'h77;
        @(negedge clk);
        flush = 1'b0; up_en = 1'b0;
        look("R8 flush beats write", mk_pc(4, 30, 0, 0), 2'd0, 1'b0, '0);
        look("R8 flush cleared others", mk_pc(7, 40, 0, 0), 2'd1, 1'b0, '0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic_and_comb();
        t_alias();
        t_tid();
        t_evict();
        t_zero_target();
        t_same_cycle();
        t_flush();
        t_flush_priority();
        finish_run();
    end
endmodule